// File: doc/BRIEF.md
# Power-up Personality Loader with Serial EEPROM Read

This block sets up a multi-function device after reset in two passes. The first pass runs in the first clock cycle after reset is released. It captures the strap inputs (mode bits, an auxiliary enable and the GPIO enable) and derives from them which functions are presented and what identifier each one reports. The second pass reads a serial EEPROM over a four-wire interface: serial clock, active-high select, data toward the memory and data from the memory. It sends the contents of the image, zone by zone, to the configuration registers through a write stream.

The image starts with a signature word at address 0. Records follow it. Each record is one header word and then a run of data words for one zone. If the signature does not match, the EEPROM pass is skipped, the defaults stay in place and the absent flag is raised. The done flag stays low until loading finishes, so the function logic can be held idle until then.

Top module: `cfg_personality_loader`

## Requirements
- R1: While reset is asserted, `cfg_done`, `ee_absent`, `wr_valid`, `mw_cs` and `mw_clk` are all 0.
- R2: The straps are captured once, in the first cycle after reset is released. Later changes on the strap pins do not affect `id_pport`, `id_gpio`, `gpio_present` or which zones are written.
- R3: Each identifier is {ID_PREFIX[8:0], mode[2:0], aux_en, gpio_en, function[1:0]}. The parallel port is function 0 and GPIO is function 2. `gpio_present` equals the captured GPIO enable.
- R4: Each EEPROM read raises `mw_cs` and then clocks out the start bit 1, the opcode 10 and the word address MSB first, one bit per `mw_clk` period. It then samples 16 data bits MSB first on the rising edges of `mw_clk`. `mw_clk` rises only while `mw_cs` is high. Words are read at ascending addresses starting from 0.
- R5: Each high phase of `mw_clk` lasts exactly HALF_DIV clock cycles.
- R6: If word 0 is not equal to SIGNATURE, no write is issued, `ee_absent` goes to 1 and `cfg_done` goes to 1.
- R7: A header word holds the zone in bits [15:12] and the data-word count in bits [11:0]. A count of 0 moves on to the next header. Each data word is written with its zone, its index within the record (counting from 0) and its value, in EEPROM order.
- R8: Zones 2 and 5 are read but never written. Zone 4 (GPIO) is read but not written when the captured GPIO enable is 0. Zones 0, 1 and 3 are always written.
- R9: A header whose zone field is above 5 ends loading. Loading also ends after the word at the last EEPROM address has been used, even in the middle of a record.
- R10: Write stream rules: once `wr_valid` is high it stays high and `wr_zone`, `wr_index` and `wr_data` stay stable until `wr_ready` is seen high at a clock edge. No EEPROM read is in progress while a write is stalled.
- R11: Once `cfg_done` is 1 it stays 1 until reset. After that no write is issued and `mw_cs` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 3 | Mode strap bits |
| strap_aux_en | input | 1 | Auxiliary enable strap |
| strap_gpio_en | input | 1 | GPIO function enable strap |
| mw_clk | output | 1 | EEPROM serial clock |
| mw_cs | output | 1 | EEPROM select, active high |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| mw_miso | input | 1 | Serial data from the EEPROM |
| wr_valid | output | 1 | A configuration write is offered |
| wr_ready | input | 1 | The register side accepts the write |
| wr_zone | output | 3 | Zone number of the write |
| wr_index | output | 12 | Word index within the record |
| wr_data | output | 16 | Data word |
| cfg_done | output | 1 | Configuration complete |
| ee_absent | output | 1 | Signature mismatch, defaults kept |
| gpio_present | output | 1 | GPIO function presented |
| id_pport | output | 16 | Parallel port function identifier |
| id_gpio | output | 16 | GPIO function identifier |

## Verification
The assertions assume that `mw_miso` changes only on a falling edge of `mw_clk`, so it is settled at every rising edge where it is sampled. They also assume the straps are steady through the capture cycle and that `wr_ready` may take any value in any cycle. The bench's EEPROM model changes its output only on falling edges of `mw_clk` and drives a constant 1 when it is absent. Straps are set while reset is held and are changed only after capture. The write acceptor runs either always ready or ready one cycle in three, which exercises stalls on every write.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int CNT_W = 12;

  typedef enum logic [2:0] {
    Z_DESC  = 3'd0,
    Z_LINK  = 3'd1,
    Z_RSV2  = 3'd2,
    Z_PPORT = 3'd3,
    Z_GPIO  = 3'd4,
    Z_RSV5  = 3'd5
  } zone_e;

  localparam logic [1:0] FN_PPORT = 2'd0;
  localparam logic [1:0] FN_GPIO  = 2'd2;

  typedef enum logic [2:0] {
    S_STRAP, S_SIG, S_HDR, S_DATA, S_WR, S_DONE
  } seq_state_e;

  function automatic logic zone_writable(input logic [2:0] z, input logic gpio_on);
    case (z)
      Z_DESC, Z_LINK, Z_PPORT: return 1'b1;
      Z_GPIO:                  return gpio_on;
      default:                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfgld_strap_ident.sv
module cfgld_strap_ident
  import cfgld_pkg::*;
#(
  parameter logic [8:0] ID_PREFIX = 9'h182
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic [2:0]  mode,
  input  logic        aux_en,
  input  logic        gpio_en,
  output logic        gpio_present,
  output logic [15:0] id_pport,
  output logic [15:0] id_gpio
);

  logic [2:0] mode_q;
  logic       aux_q;
  logic       gpio_q;
  logic       captured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      aux_q    <= 1'b0;
      gpio_q   <= 1'b0;
      captured <= 1'b0;
    end else if (capture && !captured) begin
      mode_q   <= mode;
      aux_q    <= aux_en;
      gpio_q   <= gpio_en;
      captured <= 1'b1;
    end
  end

  assign gpio_present = gpio_q;
  assign id_pport     = {ID_PREFIX, mode_q, aux_q, gpio_q, FN_PPORT};
  assign id_gpio      = {ID_PREFIX, mode_q, aux_q, gpio_q, FN_GPIO};

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(id_pport) && $stable(id_gpio) && $stable(gpio_present));

endmodule

// File: rtl/cfgld_mw_reader.sv
module cfgld_mw_reader #(
  parameter int ADDR_W   = 6,
  parameter int HALF_DIV = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [15:0]       rd_data,
  output logic              mw_clk,
  output logic              mw_cs,
  output logic              mw_mosi,
  input  logic              mw_miso
);

  localparam int CMD_W = 3 + ADDR_W;
  localparam int TOTAL = CMD_W + 16;
  localparam int BIT_W = $clog2(TOTAL + 1);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {M_IDLE, M_SHIFT, M_GAP} mstate_e;

  mstate_e          st;
  logic [CMD_W-1:0] sh;
  logic [BIT_W-1:0] bit_cnt;
  logic [DIV_W-1:0] div;

  assign mw_mosi = sh[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      sh      <= '0;
      bit_cnt <= '0;
      div     <= '0;
      mw_clk  <= 1'b0;
      mw_cs   <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        M_IDLE: begin
          if (rd_start) begin
            sh      <= {3'b110, rd_addr};
            bit_cnt <= '0;
            div     <= '0;
            mw_cs   <= 1'b1;
            st      <= M_SHIFT;
          end
        end
        M_SHIFT: begin
          if (div == DIV_END) begin
            div <= '0;
            if (!mw_clk) begin
              mw_clk <= 1'b1;
              if (bit_cnt >= BIT_W'(CMD_W))
                rd_data <= {rd_data[14:0], mw_miso};
            end else begin
              mw_clk <= 1'b0;
              sh     <= sh << 1;
              if (bit_cnt == BIT_W'(TOTAL - 1)) begin
                mw_cs   <= 1'b0;
                bit_cnt <= '0;
                st      <= M_GAP;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        M_GAP: begin
          if (div == DIV_END) begin
            div     <= '0;
            rd_done <= 1'b1;
            st      <= M_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R4
  clk_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_clk) |-> mw_cs);

  // R4
  select_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_clk);

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] SIGNATURE = 16'hC0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gpio_on,
  output logic              strap_capture,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  input  logic [15:0]       rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [2:0]        wr_zone,
  output logic [CNT_W-1:0]  wr_index,
  output logic [15:0]       wr_data,
  output logic              cfg_done,
  output logic              ee_absent
);

  seq_state_e        st;
  logic              issued;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        zone_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;
  logic [15:0]       data_q;
  logic              last_word;
  logic              writable;
  logic              advance;

  assign last_word     = &addr;
  assign writable      = zone_writable(zone_q, gpio_on);
  assign strap_capture = (st == S_STRAP);
  assign rd_addr       = addr;
  assign wr_valid      = (st == S_WR);
  assign wr_zone       = zone_q;
  assign wr_index      = idx_q;
  assign wr_data       = data_q;
  assign cfg_done      = (st == S_DONE);

  always_comb begin
    rd_start = !issued && (st == S_SIG || st == S_HDR || st == S_DATA);
    advance  = (st == S_DATA && rd_done && !writable) || (st == S_WR && wr_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_STRAP;
      issued    <= 1'b0;
      addr      <= '0;
      zone_q    <= '0;
      left_q    <= '0;
      idx_q     <= '0;
      data_q    <= '0;
      ee_absent <= 1'b0;
    end else begin
      if (rd_start) issued <= 1'b1;
      if (rd_done)  issued <= 1'b0;
      case (st)
        S_STRAP: st <= S_SIG;
        S_SIG: begin
          if (rd_done) begin
            if (rd_data != SIGNATURE) begin
              ee_absent <= 1'b1;
              st        <= S_DONE;
            end else if (last_word) begin
              st <= S_DONE;
            end else begin
              addr <= addr + 1'b1;
              st   <= S_HDR;
            end
          end
        end
        S_HDR: begin
          if (rd_done) begin
            if (rd_data[15:12] > 4'd5 || last_word) begin
              st <= S_DONE;
            end else begin
              zone_q <= rd_data[14:12];
              left_q <= rd_data[CNT_W-1:0];
              idx_q  <= '0;
              addr   <= addr + 1'b1;
              st     <= (rd_data[CNT_W-1:0] == '0) ? S_HDR : S_DATA;
            end
          end
        end
        S_DATA: begin
          if (rd_done && writable) begin
            data_q <= rd_data;
            st     <= S_WR;
          end
        end
        default: ;
      endcase
      if (advance) begin
        idx_q  <= idx_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (last_word) begin
          st <= S_DONE;
        end else begin
          addr <= addr + 1'b1;
          st   <= (left_q == CNT_W'(1)) ? S_HDR : S_DATA;
        end
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_index) && $stable(wr_zone));

  // R10
  no_read_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_start && !rd_done);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  // R11
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !rd_start && !wr_valid);

  // R8
  zone_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_zone != 3'd2 && wr_zone != 3'd5 && !(wr_zone == 3'd4 && !gpio_on));

  // R6
  absent_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_absent |-> cfg_done);

endmodule

// File: rtl/cfg_personality_loader.sv
module cfg_personality_loader
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          HALF_DIV  = 84,
  parameter logic [15:0] SIGNATURE = 16'hC0DE,
  parameter logic [8:0]  ID_PREFIX = 9'h182
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap_mode,
  input  logic        strap_aux_en,
  input  logic        strap_gpio_en,
  output logic        mw_clk,
  output logic        mw_cs,
  output logic        mw_mosi,
  input  logic        mw_miso,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [2:0]  wr_zone,
  output logic [11:0] wr_index,
  output logic [15:0] wr_data,
  output logic        cfg_done,
  output logic        ee_absent,
  output logic        gpio_present,
  output logic [15:0] id_pport,
  output logic [15:0] id_gpio
);

  logic              strap_capture;
  logic              rd_start;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_done;
  logic [15:0]       rd_data;

  cfgld_strap_ident #(.ID_PREFIX(ID_PREFIX)) u_ident (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (strap_capture),
    .mode         (strap_mode),
    .aux_en       (strap_aux_en),
    .gpio_en      (strap_gpio_en),
    .gpio_present (gpio_present),
    .id_pport     (id_pport),
    .id_gpio      (id_gpio)
  );

  cfgld_mw_reader #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) u_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .rd_addr  (rd_addr),
    .rd_done  (rd_done),
    .rd_data  (rd_data),
    .mw_clk   (mw_clk),
    .mw_cs    (mw_cs),
    .mw_mosi  (mw_mosi),
    .mw_miso  (mw_miso)
  );

  cfgld_seq #(.ADDR_W(ADDR_W), .SIGNATURE(SIGNATURE)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .gpio_on       (gpio_present),
    .strap_capture (strap_capture),
    .rd_start      (rd_start),
    .rd_addr       (rd_addr),
    .rd_done       (rd_done),
    .rd_data       (rd_data),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_zone       (wr_zone),
    .wr_index      (wr_index),
    .wr_data       (wr_data),
    .cfg_done      (cfg_done),
    .ee_absent     (ee_absent)
  );

endmodule

// File: tb/test_cfg_personality_loader.sv
module test_cfg_personality_loader;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int HD  = 2;
  localparam int CW  = 3 + AW;
  localparam logic [15:0] SIG = 16'hC0DE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap_mode = '0;
  logic strap_aux_en = 1'b0, strap_gpio_en = 1'b0;
  logic mw_clk, mw_cs, mw_mosi;
  logic miso = 1'b1;
  logic wr_valid, wr_ready;
  logic [2:0] wr_zone;
  logic [11:0] wr_index;
  logic [15:0] wr_data;
  logic cfg_done, ee_absent, gpio_present;
  logic [15:0] id_pport, id_gpio;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_personality_loader #(.ADDR_W(AW), .HALF_DIV(HD), .SIGNATURE(SIG), .ID_PREFIX(9'h182))
    i_cfg_personality_loader (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .strap_aux_en(strap_aux_en),
    .strap_gpio_en(strap_gpio_en), .mw_clk(mw_clk), .mw_cs(mw_cs), .mw_mosi(mw_mosi),
    .mw_miso(miso), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_zone(wr_zone),
    .wr_index(wr_index), .wr_data(wr_data), .cfg_done(cfg_done), .ee_absent(ee_absent),
    .gpio_present(gpio_present), .id_pport(id_pport), .id_gpio(id_gpio));

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model: changes data only on falling serial clock
  logic [15:0] rom [16];
  bit ee_en = 1'b1;
  int rise_n = 0, n_rd = 0, bad_cmd = 0;
  int rd_log [64];
  logic [2:0] cmd_sh;
  logic [AW-1:0] ad_sh;
  logic [15:0] cur_word = '1;

  always @(posedge mw_clk or posedge mw_cs or negedge rst_n) begin
    if (!rst_n) begin
      n_rd = 0; bad_cmd = 0; rise_n = 0;
    end else if (!mw_clk) begin
      rise_n = 0;
    end else if (mw_cs) begin
      if (rise_n < 3) cmd_sh = {cmd_sh[1:0], mw_mosi};
      else if (rise_n < CW) ad_sh = {ad_sh[AW-2:0], mw_mosi};
      rise_n++;
      if (rise_n == CW) begin
        if (cmd_sh != 3'b110) bad_cmd++;
        if (n_rd < 64) rd_log[n_rd] = int'(ad_sh);
        n_rd++;
        cur_word = ee_en ? rom[ad_sh] : 16'hFFFF;
      end
    end
  end

  always @(negedge mw_clk) begin
    if (mw_cs && rise_n >= CW && rise_n < CW + 16) miso = cur_word[15 - (rise_n - CW)];
    else miso = 1'b1;
  end

  // write acceptor and monitors
  bit bp_mode = 1'b0;
  int n_got = 0, cyc = 0, bp_err = 0, hi_cnt = 0, hi_min = 1000, hi_max = 0;
  int got_z [64], got_i [64], got_d [64];
  bit stalled = 1'b0, sk_prev = 1'b0;
  logic [30:0] held;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_got = 0; cyc = 0; bp_err = 0; stalled = 1'b0;
      hi_cnt = 0; hi_min = 1000; hi_max = 0; sk_prev = 1'b0; wr_ready = 1'b1;
    end else begin
      cyc++;
      wr_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
      if (stalled && wr_valid && {wr_zone, wr_index, wr_data} != held) bp_err++;
      if (wr_valid && !wr_ready && mw_cs) bp_err++;
      if (wr_valid && wr_ready) begin
        if (n_got < 64) begin
          got_z[n_got] = int'(wr_zone); got_i[n_got] = int'(wr_index); got_d[n_got] = int'(wr_data);
        end
        n_got++;
      end
      stalled = wr_valid && !wr_ready;
      held = {wr_zone, wr_index, wr_data};
      if (mw_clk) hi_cnt++;
      if (sk_prev && !mw_clk) begin
        if (hi_cnt < hi_min) hi_min = hi_cnt;
        if (hi_cnt > hi_max) hi_max = hi_cnt;
        hi_cnt = 0;
      end
      sk_prev = mw_clk;
    end
  end

  int exp_z [64], exp_i [64], exp_d [64];
  int n_exp = 0;

  task automatic push_exp(input int z, input int i, input int d);
    exp_z[n_exp] = z; exp_i[n_exp] = i; exp_d[n_exp] = d; n_exp++;
  endtask

  task automatic compare_log(input string req);
    chk(n_got == n_exp, req, "write count", n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      chk(got_z[k] == exp_z[k] && got_i[k] == exp_i[k] && got_d[k] == exp_d[k], req,
          $sformatf("write %0d zone/index/data", k),
          (got_z[k] << 28) | (got_i[k] << 16) | got_d[k],
          (exp_z[k] << 28) | (exp_i[k] << 16) | exp_d[k]);
    end
  endtask

  task automatic clear_rom();
    for (int k = 0; k < 16; k++) rom[k] = 16'hF000;
    n_exp = 0;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic a, input logic g);
    rst_n = 1'b0;
    strap_mode = m; strap_aux_en = a; strap_gpio_en = g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    for (int k = 0; k < 20000 && !cfg_done; k++) @(negedge clk);
    chk(cfg_done == 1'b1, req, "cfg_done reached", int'(cfg_done), 1);
  endtask

  function automatic int exp_id(input logic [2:0] m, input logic a, input logic g, input logic [1:0] fn);
    return int'({9'h182, m, a, g, fn});
  endfunction

  task automatic load_main_image();
    clear_rom();
    rom[0] = SIG;
    rom[1] = 16'h1002; rom[2] = 16'h1111; rom[3] = 16'h2222;
    rom[4] = 16'h3001; rom[5] = 16'h3333;
    rom[6] = 16'h2001; rom[7] = 16'hDEAD;
    rom[8] = 16'h4002; rom[9] = 16'h4444; rom[10] = 16'h4545;
    rom[11] = 16'h5001; rom[12] = 16'hBEEF;
    rom[13] = 16'h0001; rom[14] = 16'h0A0A;
    rom[15] = 16'hF000;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    chk(!cfg_done && !ee_absent && !wr_valid && !mw_cs && !mw_clk, "R1", "outputs in reset",
        {cfg_done, ee_absent, wr_valid, mw_cs, mw_clk}, 0);
  endtask

  task automatic t_main_gpio_on();
    bp_mode = 1'b0; ee_en = 1'b1;
    load_main_image();
    push_exp(1, 0, 16'h1111); push_exp(1, 1, 16'h2222); push_exp(3, 0, 16'h3333);
    push_exp(4, 0, 16'h4444); push_exp(4, 1, 16'h4545); push_exp(0, 0, 16'h0A0A);
    do_reset(3'b101, 1'b0, 1'b1);
    chk(cfg_done == 1'b0, "R11", "not done while loading", int'(cfg_done), 0);
    wait_done("R7");
    compare_log("R7");
    chk(ee_absent == 1'b0, "R6", "ee_absent with good signature", int'(ee_absent), 0);
    // R3
    chk(int'(id_pport) == exp_id(3'b101, 1'b0, 1'b1, 2'd0), "R3", "id_pport", int'(id_pport), exp_id(3'b101, 1'b0, 1'b1, 2'd0));
    chk(int'(id_gpio) == exp_id(3'b101, 1'b0, 1'b1, 2'd2), "R3", "id_gpio", int'(id_gpio), exp_id(3'b101, 1'b0, 1'b1, 2'd2));
    chk(gpio_present == 1'b1, "R3", "gpio_present", int'(gpio_present), 1);
    // R4
    chk(n_rd == 16 && bad_cmd == 0, "R4", "reads and bad commands", n_rd * 256 + bad_cmd, 16 * 256);
    for (int k = 0; k < 16 && k < n_rd; k++)
      chk(rd_log[k] == k, "R4", $sformatf("read %0d address", k), rd_log[k], k);
    // R5
    chk(hi_min == HD && hi_max == HD, "R5", "serial clock high phase", hi_min * 256 + hi_max, HD * 256 + HD);
    // R11
    repeat (200) @(negedge clk);
    chk(cfg_done && n_rd == 16 && n_got == 6 && !mw_cs, "R11", "quiet after done",
        n_rd * 256 + n_got, 16 * 256 + 6);
  endtask

  task automatic t_gpio_off_strap_change();
    bp_mode = 1'b0; ee_en = 1'b1;
    load_main_image();
    push_exp(1, 0, 16'h1111); push_exp(1, 1, 16'h2222); push_exp(3, 0, 16'h3333);
    push_exp(0, 0, 16'h0A0A);
    do_reset(3'b010, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    strap_mode = 3'b101; strap_aux_en = 1'b0; strap_gpio_en = 1'b1;
    wait_done("R8");
    // R8 zone 4 dropped with GPIO off, zones 2 and 5 dropped always
    compare_log("R8");
    // R2
    chk(int'(id_pport) == exp_id(3'b010, 1'b1, 1'b0, 2'd0), "R2", "id_pport after strap change", int'(id_pport), exp_id(3'b010, 1'b1, 1'b0, 2'd0));
    chk(int'(id_gpio) == exp_id(3'b010, 1'b1, 1'b0, 2'd2), "R2", "id_gpio after strap change", int'(id_gpio), exp_id(3'b010, 1'b1, 1'b0, 2'd2));
    chk(gpio_present == 1'b0, "R2", "gpio_present after strap change", int'(gpio_present), 0);
  endtask

  task automatic t_backpressure();
    bp_mode = 1'b1; ee_en = 1'b1;
    load_main_image();
    push_exp(1, 0, 16'h1111); push_exp(1, 1, 16'h2222); push_exp(3, 0, 16'h3333);
    push_exp(4, 0, 16'h4444); push_exp(4, 1, 16'h4545); push_exp(0, 0, 16'h0A0A);
    do_reset(3'b000, 1'b1, 1'b1);
    wait_done("R10");
    compare_log("R10");
    chk(bp_err == 0, "R10", "stall violations", bp_err, 0);
    bp_mode = 1'b0;
  endtask

  task automatic t_absent();
    ee_en = 1'b0;
    load_main_image();
    do_reset(3'b001, 1'b0, 1'b1);
    wait_done("R6");
    chk(ee_absent == 1'b1, "R6", "ee_absent no device", int'(ee_absent), 1);
    chk(n_got == 0 && n_rd == 1, "R6", "writes/reads no device", n_got * 256 + n_rd, 1);
    ee_en = 1'b1;
    load_main_image();
    rom[0] = SIG ^ 16'h0001;
    do_reset(3'b001, 1'b0, 1'b1);
    wait_done("R6");
    chk(ee_absent == 1'b1 && n_got == 0, "R6", "bad signature", int'(ee_absent) * 256 + n_got, 256);
  endtask

  task automatic t_end_conditions();
    ee_en = 1'b1;
    clear_rom();
    rom[0] = SIG; rom[1] = 16'h3001; rom[2] = 16'h1234;
    rom[3] = 16'h6001; rom[4] = 16'h5555; rom[5] = 16'h3001; rom[6] = 16'h7777;
    push_exp(3, 0, 16'h1234);
    do_reset(3'b000, 1'b0, 1'b1);
    wait_done("R9");
    compare_log("R9");
    chk(n_rd == 4, "R9", "reads before zone-6 header stop", n_rd, 4);
    clear_rom();
    rom[0] = SIG; rom[1] = 16'h0080; rom[2] = 16'h0000;
    for (int k = 2; k < 16; k++) begin
      rom[k] = 16'h0100 + 16'(k);
      push_exp(0, k - 2, 16'h0100 + k);
    end
    do_reset(3'b000, 1'b0, 1'b1);
    wait_done("R9");
    compare_log("R9");
    chk(n_rd == 16, "R9", "reads at last address", n_rd, 16);
    clear_rom();
    rom[0] = SIG; rom[1] = 16'h1000; rom[2] = 16'h3001; rom[3] = 16'h9999;
    push_exp(3, 0, 16'h9999);
    do_reset(3'b000, 1'b0, 1'b1);
    wait_done("R7");
    // R7 zero-count header skipped
    compare_log("R7");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_main_gpio_on();
    t_gpio_off_strap_change();
    t_backpressure();
    t_absent();
    t_end_conditions();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule